// File: doc/BRIEF.md
# Software-Managed Set-Associative TLB

This block translates virtual addresses to physical page frames for 4 KB pages. Software loads and inspects it through three control registers. Lookup is purely combinational. A 32-bit virtual address goes in, and in the same cycle the block reports a hit, the 20-bit frame number and the read, write and execute permissions. The virtual page number (address bits [31:12]) selects a set through its low bits. Every way of that set is compared, and the lowest-numbered matching way wins. A way matches only when it is valid, its stored page number equals the lookup page number, and either it is global or its stored process ID equals the current process ID.

Software manages the entries through three registers: a page-entry address register, an access register and a miscellaneous register. To fill an entry, software sets the write-enable flag in the miscellaneous register and then writes the access register. Each such write stores one entry and advances the way pointer. To read an entry back, software writes the miscellaneous register with its read flag set. The addressed entry's fields are then copied into the read-back values of all three registers. Pages whose number is 0xC0000 or above are stored but never marked valid.

The parameters are the way count, the entry count and the PID width. Ways and entries must be powers of two, and there must be at least two ways. Entry `i` of the storage holds way `i / sets`, set `i % sets`.

Top module: `swtlb`

## Requirements
- R1: After reset the three register read-backs are zero (csr_sel 0 = page-entry address, 1 = access, 2 = miscellaneous), the current PID and the way pointer are zero, and every lookup misses.
- R2: A lookup hits when a valid entry in the indexed set has a page number equal to lk_vaddr[31:12] and a PID equal to the current PID. The hit returns the entry's frame number and its R/W/X bits. The access word layout is: frame [19:0], X bit 20, W bit 21, R bit 22, cacheable bit 23, global bit 24, ignored [31:25].
- R3: An entry written with access bit 24 (global) set hits regardless of the current PID.
- R4: When no way hits, lk_hit is 0 and lk_pfn, lk_rd, lk_wr and lk_ex are all 0.
- R5: When several ways of a set hit, the lowest-numbered way supplies the frame and permissions.
- R6: A write to the access register while the miscellaneous write-enable flag (bit 18) is set stores an entry. The entry goes to the way in the way field (miscellaneous bits starting at 20) and to the set given by the page number in page-entry address bits [21:2]. It takes the current PID and keeps only access bits [23:0] plus the global bit. With the flag clear, the write stores nothing.
- R7: An entry whose page number is 0xC0000 or above is stored but marked invalid: it never hits, but it can still be read back.
- R8: Each entry store advances the way field of the miscellaneous read-back by one, modulo the way count.
- R9: Writing the miscellaneous register with the read flag (bit 19) set reads the entry addressed by the written way field and the page-entry address page number. The access read-back becomes its kept upper field [31:25], ORed with the entry data and the global bit. The miscellaneous read-back becomes the written value with its PID field (bits starting at 4) replaced by the entry's PID. The page-entry address field [21:2] becomes the entry's page number. Without the read flag, the miscellaneous read-back is the written value.
- R10: A write to the page-entry address register changes every read-back bit except [21:2]. A write to the access register does not change the access read-back.
- R11: The current PID is the PID field of the last value written to the miscellaneous register, not of its read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 page-entry address, 1 access, 2 miscellaneous |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read-back of the selected register (zero for select 3) |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 20 | Physical frame number of the hitting entry |
| lk_rd | output | 1 | Read permission |
| lk_wr | output | 1 | Write permission |
| lk_ex | output | 1 | Execute permission |

## Verification
Lookups are tried in several patterns:
- An exact page and PID match, and the same page with a different PID. Together these separate PID compare from page compare.
- A global entry under a foreign PID, which separates the bypass from a plain match.
- The same page filled into both ways, which exposes the way priority.
- A page in the upper region, which shows the valid-flag rule independently of storage, because the entry still reads back.

Register tests show that a fill needs the write-enable flag and that the way pointer wraps. They also check that the read flag updates all three read-backs, with data masking and the global bit, and that lookup follows the written PID rather than the PID that a read put into the read-back.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
    localparam int VPN_W        = 20;
    localparam int PFN_W        = 20;
    localparam int PAGE_SHIFT   = 12;
    localparam int PTE_VPN_LSB  = 2;
    localparam int ACC_G        = 24;
    localparam int ACC_DATA_W   = 24;
    localparam int MISC_PID_LSB = 4;
    localparam int MISC_WE      = 18;
    localparam int MISC_RD      = 19;
    localparam int MISC_WAY_LSB = 20;
    localparam logic [VPN_W-1:0] VALID_LIMIT = 20'hC0000;
    localparam logic [31:0] PTE_VPN_MASK = 32'h003F_FFFC;
    localparam logic [31:0] ACC_KEEP_MASK = 32'hFE00_0000;

    typedef enum logic [1:0] {
        SEL_PTE  = 2'd0,
        SEL_ACC  = 2'd1,
        SEL_MISC = 2'd2,
        SEL_NONE = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic             c;
        logic             r;
        logic             w;
        logic             x;
        logic [PFN_W-1:0] pfn;
    } tlb_data_t;
endpackage

// File: rtl/swtlb_store.sv
module swtlb_store
    import swtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PID_W   = 8,
    parameter int IDX_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [VPN_W-1:0]        wr_vpn,
    input  logic                    wr_g,
    input  logic                    wr_v,
    input  logic [PID_W-1:0]        wr_pid,
    input  tlb_data_t               wr_data,
    output logic [VPN_W-1:0]        e_vpn  [ENTRIES],
    output logic [ENTRIES-1:0]      e_g,
    output logic [ENTRIES-1:0]      e_v,
    output logic [PID_W-1:0]        e_pid  [ENTRIES],
    output tlb_data_t               e_data [ENTRIES]
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_v <= '0;
        end else if (wr_en) begin
            e_v[wr_idx] <= wr_v;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            e_vpn[wr_idx]  <= wr_vpn;
            e_g[wr_idx]    <= wr_g;
            e_pid[wr_idx]  <= wr_pid;
            e_data[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/swtlb_lookup.sv
module swtlb_lookup
    import swtlb_pkg::*;
#(
    parameter int WAYS    = 2,
    parameter int SETS    = 8,
    parameter int ENTRIES = 16,
    parameter int PID_W   = 8,
    parameter int SET_W   = 3,
    parameter int WAY_W   = 1
) (
    input  logic [VPN_W-1:0]   vpn,
    input  logic [PID_W-1:0]   cur_pid,
    input  logic [VPN_W-1:0]   e_vpn  [ENTRIES],
    input  logic [ENTRIES-1:0] e_g,
    input  logic [ENTRIES-1:0] e_v,
    input  logic [PID_W-1:0]   e_pid  [ENTRIES],
    input  tlb_data_t          e_data [ENTRIES],
    output logic               hit,
    output tlb_data_t          hit_data
);
    localparam int IDX_W = WAY_W + SET_W;

    logic [WAYS-1:0] way_hit;
    tlb_data_t       way_data [WAYS];
    logic [SET_W-1:0] set_idx;

    assign set_idx = vpn[SET_W-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [IDX_W-1:0] idx;
        assign idx = {WAY_W'(w), set_idx};
        assign way_hit[w]  = e_v[idx] && (e_vpn[idx] == vpn) &&
                             (e_g[idx] || (e_pid[idx] == cur_pid));
        assign way_data[w] = e_data[idx];
    end

    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                hit      = 1'b1;
                hit_data = way_data[w];
            end
        end
    end
endmodule

// File: rtl/swtlb_csr.sv
module swtlb_csr
    import swtlb_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int PID_W = 8,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  csr_sel_e         csr_sel,
    input  logic [31:0]      csr_wdata,
    input  logic [VPN_W-1:0] rd_vpn,
    input  logic             rd_g,
    input  logic [PID_W-1:0] rd_pid,
    input  tlb_data_t        rd_data,
    output logic [31:0]      csr_rdata,
    output logic [PID_W-1:0] cur_pid,
    output logic [VPN_W-1:0] mgmt_vpn,
    output logic [WAY_W-1:0] rd_way,
    output logic             fill_en,
    output logic [WAY_W-1:0] fill_way,
    output logic [31:0]      pte_q,
    output logic [31:0]      acc_q,
    output logic [31:0]      misc_q
);
    localparam logic [31:0] PID_MASK = ((32'd1 << PID_W) - 32'd1) << MISC_PID_LSB;

    logic [WAY_W-1:0] next_way;

    assign rd_way   = csr_wdata[MISC_WAY_LSB +: WAY_W];
    assign fill_way = misc_q[MISC_WAY_LSB +: WAY_W];
    assign fill_en  = csr_we && (csr_sel == SEL_ACC) && misc_q[MISC_WE];
    assign next_way = ((int'(fill_way) + 1) == WAYS) ? '0 : fill_way + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pte_q    <= '0;
            acc_q    <= '0;
            misc_q   <= '0;
            cur_pid  <= '0;
            mgmt_vpn <= '0;
        end else if (csr_we) begin
            unique case (csr_sel)
                SEL_PTE: begin
                    pte_q    <= (csr_wdata & ~PTE_VPN_MASK) | (pte_q & PTE_VPN_MASK);
                    mgmt_vpn <= csr_wdata[PTE_VPN_LSB +: VPN_W];
                end
                SEL_ACC: begin
                    if (fill_en) begin
                        misc_q[MISC_WAY_LSB +: WAY_W] <= next_way;
                    end
                end
                SEL_MISC: begin
                    cur_pid <= csr_wdata[MISC_PID_LSB +: PID_W];
                    if (csr_wdata[MISC_RD]) begin
                        acc_q  <= (acc_q & ACC_KEEP_MASK) | 32'(rd_data) |
                                  (32'(rd_g) << ACC_G);
                        misc_q <= (csr_wdata & ~PID_MASK) |
                                  (32'(rd_pid) << MISC_PID_LSB);
                        pte_q  <= (pte_q & ~PTE_VPN_MASK) |
                                  (32'(rd_vpn) << PTE_VPN_LSB);
                    end else begin
                        misc_q <= csr_wdata;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (csr_sel)
            SEL_PTE:  csr_rdata = pte_q;
            SEL_ACC:  csr_rdata = acc_q;
            SEL_MISC: csr_rdata = misc_q;
            default:  csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/swtlb.sv
module swtlb
    import swtlb_pkg::*;
#(
    parameter int NUM_WAYS    = 2,
    parameter int NUM_ENTRIES = 16,
    parameter int PID_W       = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic [1:0]  csr_sel,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic [31:0] lk_vaddr,
    output logic        lk_hit,
    output logic [19:0] lk_pfn,
    output logic        lk_rd,
    output logic        lk_wr,
    output logic        lk_ex
);
    localparam int SETS  = NUM_ENTRIES / NUM_WAYS;
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int IDX_W = WAY_W + SET_W;

    logic [VPN_W-1:0]     e_vpn  [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] e_g;
    logic [NUM_ENTRIES-1:0] e_v;
    logic [PID_W-1:0]     e_pid  [NUM_ENTRIES];
    tlb_data_t            e_data [NUM_ENTRIES];

    logic [PID_W-1:0] cur_pid;
    logic [VPN_W-1:0] mgmt_vpn;
    logic [WAY_W-1:0] rd_way;
    logic [WAY_W-1:0] fill_way;
    logic             fill_en;
    logic [31:0]      pte_q;
    logic [31:0]      acc_q;
    logic [31:0]      misc_q;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] fill_idx;
    tlb_data_t        hit_data;
    logic             unused_offset;

    assign unused_offset = ^lk_vaddr[PAGE_SHIFT-1:0];
    assign rd_idx   = {rd_way, mgmt_vpn[SET_W-1:0]};
    assign fill_idx = {fill_way, mgmt_vpn[SET_W-1:0]};

    swtlb_csr #(.WAYS(NUM_WAYS), .PID_W(PID_W), .WAY_W(WAY_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_sel   (csr_sel_e'(csr_sel)),
        .csr_wdata (csr_wdata),
        .rd_vpn    (e_vpn[rd_idx]),
        .rd_g      (e_g[rd_idx]),
        .rd_pid    (e_pid[rd_idx]),
        .rd_data   (e_data[rd_idx]),
        .csr_rdata (csr_rdata),
        .cur_pid   (cur_pid),
        .mgmt_vpn  (mgmt_vpn),
        .rd_way    (rd_way),
        .fill_en   (fill_en),
        .fill_way  (fill_way),
        .pte_q     (pte_q),
        .acc_q     (acc_q),
        .misc_q    (misc_q)
    );

    swtlb_store #(.ENTRIES(NUM_ENTRIES), .PID_W(PID_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fill_en),
        .wr_idx  (fill_idx),
        .wr_vpn  (mgmt_vpn),
        .wr_g    (csr_wdata[ACC_G]),
        .wr_v    (mgmt_vpn < VALID_LIMIT),
        .wr_pid  (cur_pid),
        .wr_data (tlb_data_t'(csr_wdata[ACC_DATA_W-1:0])),
        .e_vpn   (e_vpn),
        .e_g     (e_g),
        .e_v     (e_v),
        .e_pid   (e_pid),
        .e_data  (e_data)
    );

    swtlb_lookup #(
        .WAYS(NUM_WAYS), .SETS(SETS), .ENTRIES(NUM_ENTRIES),
        .PID_W(PID_W), .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_lookup (
        .vpn      (lk_vaddr[31:PAGE_SHIFT]),
        .cur_pid  (cur_pid),
        .e_vpn    (e_vpn),
        .e_g      (e_g),
        .e_v      (e_v),
        .e_pid    (e_pid),
        .e_data   (e_data),
        .hit      (lk_hit),
        .hit_data (hit_data)
    );

    assign lk_pfn = hit_data.pfn;
    assign lk_rd  = hit_data.r;
    assign lk_wr  = hit_data.w;
    assign lk_ex  = hit_data.x;
endmodule

// File: rtl/swtlb_chk.sv
module swtlb_chk #(
    parameter int NUM_WAYS = 2,
    parameter int WAY_W    = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_we,
    input logic [1:0]  csr_sel,
    input logic        lk_hit,
    input logic [19:0] lk_pfn,
    input logic        lk_rd,
    input logic        lk_wr,
    input logic        lk_ex,
    input logic        fill_en,
    input logic [31:0] pte_q,
    input logic [31:0] acc_q,
    input logic [31:0] misc_q
);
    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pfn == 20'd0 && !lk_rd && !lk_wr && !lk_ex));

    // R8
    way_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (int'(misc_q[20 +: WAY_W]) ==
                     ((int'($past(misc_q[20 +: WAY_W])) + 1) % NUM_WAYS)));

    // R10
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_sel == 2'd1) |=> $stable(acc_q));

    // R10
    pte_vpn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_sel == 2'd0) |=> $stable(pte_q[21:2]));
endmodule

bind swtlb swtlb_chk #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .csr_we  (csr_we),
    .csr_sel (csr_sel),
    .lk_hit  (lk_hit),
    .lk_pfn  (lk_pfn),
    .lk_rd   (lk_rd),
    .lk_wr   (lk_wr),
    .lk_ex   (lk_ex),
    .fill_en (fill_en),
    .pte_q   (pte_q),
    .acc_q   (acc_q),
    .misc_q  (misc_q)
);

// File: tb/test_swtlb.sv
`timescale 1ns/1ps
module test_swtlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_sel = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [19:0] lk_pfn;
    logic        lk_rd, lk_wr, lk_ex;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    swtlb i_swtlb (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_rd(lk_rd), .lk_wr(lk_wr),
        .lk_ex(lk_ex)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        csr_sel = sel; csr_wdata = data; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [31:0] data);
        csr_sel = sel; #1; data = csr_rdata;
    endtask

    task automatic look(logic [31:0] va, output logic [31:0] res);
        lk_vaddr = va; #1;
        res = {lk_hit, lk_rd, lk_wr, lk_ex, 8'd0, lk_pfn};
    endtask

    function automatic logic [31:0] lres(bit h, bit r, bit w, bit x, logic [19:0] pfn);
        return {h, r, w, x, 8'd0, pfn};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 pte reset", v, 32'h0);
        rd(2'd1, v); check("R1 acc reset", v, 32'h0);
        rd(2'd2, v); check("R1 misc reset", v, 32'h0);
        look(32'h0000_0000, v); check("R1 lookup miss after reset", v, 32'h0);
    endtask

    task automatic t_fill_hit();
        logic [31:0] v;
        wr(2'd0, 32'h0000_0048);
        wr(2'd2, 32'h0004_0050);
        wr(2'd1, 32'h005A_BCDE);
        rd(2'd2, v); check("R8 way advance", v, 32'h0014_0050);
        look(32'h0001_2345, v); check("R2 pid match hit", v, lres(1, 1, 0, 1, 20'hABCDE));
    endtask

    task automatic t_pid_miss();
        logic [31:0] v;
        wr(2'd2, 32'h0004_0060);
        rd(2'd2, v); check("R9 misc plain write", v, 32'h0004_0060);
        look(32'h0001_2000, v); check("R4 pid mismatch zero", v, 32'h0);
    endtask

    task automatic t_global();
        logic [31:0] v;
        wr(2'd0, 32'h0000_00CC);
        wr(2'd2, 32'h0004_0050);
        wr(2'd1, 32'hFF40_0033);
        wr(2'd2, 32'h0000_0090);
        look(32'h0003_3ABC, v); check("R3 global bypass", v, lres(1, 1, 0, 0, 20'h00033));
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(2'd0, 32'h0000_0110);
        wr(2'd2, 32'h0004_0010);
        wr(2'd1, 32'h0041_1111);
        rd(2'd2, v); check("R8 way 0 to 1", v, 32'h0014_0010);
        wr(2'd1, 32'h0022_2222);
        rd(2'd2, v); check("R8 way wrap", v, 32'h0004_0010);
        look(32'h0004_4000, v); check("R5 way0 priority", v, lres(1, 1, 0, 0, 20'h11111));
    endtask

    task automatic t_no_we();
        logic [31:0] v, a0;
        wr(2'd0, 32'h0000_0154);
        rd(2'd0, v); check("R10 pte vpn readback held", v, 32'h0);
        wr(2'd2, 32'h0000_0010);
        rd(2'd1, a0);
        wr(2'd1, 32'h0043_3333);
        rd(2'd1, v); check("R10 acc readback held", v, a0);
        rd(2'd2, v); check("R6 no way advance without enable", v, 32'h0000_0010);
        look(32'h0005_5000, v); check("R6 no store without enable", v, 32'h0);
    endtask

    task automatic t_upper();
        logic [31:0] v;
        wr(2'd0, 32'h0030_0004);
        wr(2'd2, 32'h0004_0010);
        wr(2'd1, 32'h0064_4444);
        look(32'hC000_1000, v); check("R7 upper page invalid", v, 32'h0);
        wr(2'd2, 32'h0008_0000);
        rd(2'd1, v); check("R7 upper entry acc readback", v, 32'h0064_4444);
        rd(2'd2, v); check("R9 misc pid from entry", v, 32'h0008_0010);
        rd(2'd0, v); check("R9 pte vpn from entry", v, 32'h0030_0004);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(2'd0, 32'h8000_0049);
        rd(2'd0, v); check("R10 pte other fields written", v, 32'h8030_0005);
        wr(2'd2, 32'h0008_0030);
        rd(2'd1, v); check("R9 acc from entry", v, 32'h005A_BCDE);
        rd(2'd2, v); check("R9 misc pid replaced", v, 32'h0008_0050);
        rd(2'd0, v); check("R9 pte vpn replaced", v, 32'h8000_0049);
        look(32'h0001_2000, v); check("R11 written pid used", v, 32'h0);
        wr(2'd0, 32'h0000_00CC);
        wr(2'd2, 32'h0008_0000);
        rd(2'd1, v); check("R9 global bit and data mask", v, 32'h0140_0033);
        rd(2'd3, v); check("R9 unused select reads zero", v, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_hit();
        t_pid_miss();
        t_global();
        t_priority();
        t_no_we();
        t_upper();
        t_readback();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule